// File: doc/BRIEF.md
# Multi-Position Rotate-Through-Carry Unit

This datapath unit rotates a register operand to the right through the carry flag by one to four places in one operation. The operand and the carry form a closed ring, and each position moves the carry into the top bit of the active width while the bottom bit leaves into the carry. Two widths are available. The wide mode rotates all 20 bits. The narrow mode rotates only the low 16 bits and clears the upper four bits of the result.

A controller presents the operand, the incoming carry, a count, the width select and the mode bits of the status register, then pulses `start`. On the next clock edge the unit registers the result, the new N, Z, C and V flags and the copied mode bits, and it pulses `done`. If the count is outside 1 to 4, the unit leaves every output register as it was and pulses `err` instead of `done`.

Top module: `ring_rotate_unit`

## Requirements
- R1: With count n in 1..4 (the 3-bit `count` input is the binary value of n), the result is the operand rotated right by exactly n places through a ring made of the carry and the active bits.
- R2: When `wide_mode` is 1, the ring covers bits 19:0, and the carry enters bit 19 at each place.
- R3: When `wide_mode` is 0, the ring covers bits 15:0 and the carry enters bit 15 at each place. Operand bits 19:16 do not enter the ring, and result bits 19:16 are 0.
- R4: The carry flag after the operation equals operand bit n-1.
- R5: `flag_n` equals result bit 19 in wide mode and result bit 15 in narrow mode.
- R6: `flag_z` is 1 exactly when all 20 result bits are 0.
- R7: `flag_v` is 0 after every completed operation.
- R8: After a completed operation, `mode_out` equals the `mode_in` value presented with the start strobe.
- R9: A start with count 0, 5, 6 or 7 changes none of `result`, the four flags or `mode_out`. It raises `err` for one cycle, and `done` stays 0.
- R10: The outputs change on the clock edge after a `start` cycle. `done` is a single-cycle pulse, and without `start` the outputs hold.
- R11: A synchronous active-high reset clears `result`, all flags, `mode_out`, `done` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one rotate operation |
| operand | input | 20 | Value to rotate |
| carry_in | input | 1 | Incoming carry flag |
| count | input | 3 | Number of places, valid from 1 to 4 |
| wide_mode | input | 1 | 1 selects 20-bit rotation, 0 selects 16-bit rotation |
| mode_in | input | 3 | Status register mode bits to be preserved |
| result | output | 20 | Registered rotate result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag, always cleared |
| mode_out | output | 3 | Preserved mode bits |
| done | output | 1 | One-cycle pulse marking a completed operation |
| err | output | 1 | One-cycle pulse marking a rejected count |

## Verification
The assertions assume that the inputs are stable around the clock edge, so the values seen through `$past` one cycle after a strobe are the values that the registers captured. They also assume that `start` is never asserted during reset. The bench changes inputs only on the falling edge, releases reset before the first strobe, and samples one nanosecond after the rising edge. Each scenario issues a single-cycle strobe followed by an idle cycle, so every `done` or `err` pulse can be tied to exactly one request.

// File: rtl/ring_rot_pkg.sv
package ring_rot_pkg;

  localparam int unsigned WIDE_W   = 20;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned STEP_MAX = 4;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned MODE_W   = 3;

  typedef struct packed {
    logic neg;
    logic zero;
    logic cy;
    logic ovf;
  } rot_flags_t;

  // A count is accepted when it names between one and STEP_MAX places.
  function automatic logic count_in_range(input logic [CNT_W-1:0] cnt);
    return (cnt != '0) && (int'(cnt) <= int'(STEP_MAX));
  endfunction

endpackage

// File: rtl/rot_ring_core.sv
module rot_ring_core #(
  parameter int unsigned DATA_W   = ring_rot_pkg::WIDE_W,
  parameter int unsigned NARROW_W = ring_rot_pkg::NARROW_W,
  parameter int unsigned STEP_MAX = ring_rot_pkg::STEP_MAX,
  parameter int unsigned CNT_W    = ring_rot_pkg::CNT_W
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic              wide_mode,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rot_value,
  output logic              rot_carry
);
  localparam int unsigned PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] stage_v [0:STEP_MAX];
  logic              stage_c [0:STEP_MAX];

  assign stage_v[0] = operand;
  assign stage_c[0] = carry_in;

  // One ring position per stage; the bit that leaves is always bit 0.
  for (genvar s = 0; s < STEP_MAX; s++) begin : g_step
    logic [DATA_W-1:0] wide_next;
    logic [DATA_W-1:0] narrow_next;
    assign wide_next   = {stage_c[s], stage_v[s][DATA_W-1:1]};
    assign narrow_next = {{PAD_W{1'b0}}, stage_c[s], stage_v[s][NARROW_W-1:1]};
    assign stage_v[s+1] = wide_mode ? wide_next : narrow_next;
    assign stage_c[s+1] = stage_v[s][0];
  end

  always_comb begin
    rot_value = stage_v[1];
    rot_carry = stage_c[1];
    for (int k = 1; k <= int'(STEP_MAX); k++) begin
      if (int'(count) == k) begin
        rot_value = stage_v[k];
        rot_carry = stage_c[k];
      end
    end
  end
endmodule

// File: rtl/rot_flag_calc.sv
module rot_flag_calc #(
  parameter int unsigned DATA_W   = ring_rot_pkg::WIDE_W,
  parameter int unsigned NARROW_W = ring_rot_pkg::NARROW_W
) (
  input  logic [DATA_W-1:0]         rot_value,
  input  logic                      rot_carry,
  input  logic                      wide_mode,
  output ring_rot_pkg::rot_flags_t  flags
);
  always_comb begin
    flags.neg  = wide_mode ? rot_value[DATA_W-1] : rot_value[NARROW_W-1];
    flags.zero = (rot_value == '0);
    flags.cy   = rot_carry;
    flags.ovf  = 1'b0;
  end
endmodule

// File: rtl/rot_ctrl_regs.sv
module rot_ctrl_regs #(
  parameter int unsigned DATA_W = ring_rot_pkg::WIDE_W,
  parameter int unsigned MODE_W = ring_rot_pkg::MODE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accept_op,
  input  logic                     reject_op,
  input  logic [DATA_W-1:0]        value_next,
  input  ring_rot_pkg::rot_flags_t flags_next,
  input  logic [MODE_W-1:0]        mode_next,
  output logic [DATA_W-1:0]        value_q,
  output ring_rot_pkg::rot_flags_t flags_q,
  output logic [MODE_W-1:0]        mode_q,
  output logic                     done_q,
  output logic                     err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      flags_q <= '0;
      mode_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= accept_op;
      err_q  <= reject_op;
      if (accept_op) begin
        value_q <= value_next;
        flags_q <= flags_next;
        mode_q  <= mode_next;
      end
    end
  end

  assert_rejected_holds_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($stable(value_q) && $stable(flags_q) && $stable(mode_q)));

  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(done_q && err_q));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(value_q) && $stable(flags_q) && $stable(mode_q)));
endmodule

// File: rtl/ring_rotate_unit.sv
module ring_rotate_unit #(
  parameter int unsigned DATA_W   = ring_rot_pkg::WIDE_W,
  parameter int unsigned NARROW_W = ring_rot_pkg::NARROW_W,
  parameter int unsigned STEP_MAX = ring_rot_pkg::STEP_MAX,
  parameter int unsigned CNT_W    = ring_rot_pkg::CNT_W,
  parameter int unsigned MODE_W   = ring_rot_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic [CNT_W-1:0]  count,
  input  logic              wide_mode,
  input  logic [MODE_W-1:0] mode_in,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic [MODE_W-1:0] mode_out,
  output logic              done,
  output logic              err
);
  import ring_rot_pkg::*;

  localparam int unsigned PAD_W = DATA_W - NARROW_W;

  // Named internal events for the checks below.
  logic              count_ok;
  logic              accept_op;
  logic              reject_op;
  logic [CNT_W-1:0]  exit_bit_idx;
  logic [DATA_W-1:0] rot_value;
  logic              rot_carry;
  rot_flags_t        flags_next;
  rot_flags_t        flags_q;

  assign count_ok     = count_in_range(count);
  assign accept_op    = start && count_ok;
  assign reject_op    = start && !count_ok;
  assign exit_bit_idx = count - CNT_W'(1);

  rot_ring_core #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .STEP_MAX(STEP_MAX), .CNT_W(CNT_W)
  ) core_i (
    .operand   (operand),
    .carry_in  (carry_in),
    .wide_mode (wide_mode),
    .count     (count),
    .rot_value (rot_value),
    .rot_carry (rot_carry)
  );

  rot_flag_calc #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) flags_i (
    .rot_value (rot_value),
    .rot_carry (rot_carry),
    .wide_mode (wide_mode),
    .flags     (flags_next)
  );

  rot_ctrl_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .accept_op  (accept_op),
    .reject_op  (reject_op),
    .value_next (rot_value),
    .flags_next (flags_next),
    .mode_next  (mode_in),
    .value_q    (result),
    .flags_q    (flags_q),
    .mode_q     (mode_out),
    .done_q     (done),
    .err_q      (err)
  );

  assign flag_n = flags_q.neg;
  assign flag_z = flags_q.zero;
  assign flag_c = flags_q.cy;
  assign flag_v = flags_q.ovf;

  assert_carry_from_bit_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_c == $past(operand[exit_bit_idx])));

  assert_narrow_upper_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(wide_mode)) |-> (result[DATA_W-1:NARROW_W] == PAD_W'(0)));

  assert_top_bit_from_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (done && $past(wide_mode) && ($past(count) == CNT_W'(1)))
      |-> (result[DATA_W-1] == $past(carry_in)));

  assert_overflow_clear_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !flag_v);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_z == (result == '0)));

  assert_mode_copied_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (mode_out == $past(mode_in)));

  assert_valid_gives_done_R10: assert property (@(posedge clk) disable iff (rst)
    accept_op |=> (done && !err));

  assert_invalid_gives_err_R9: assert property (@(posedge clk) disable iff (rst)
    reject_op |=> (err && !done));
endmodule

// File: tb/ring_rotate_unit_tb_top.sv
`timescale 1ns/1ps
module ring_rotate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [19:0] operand;
  logic        carry_in;
  logic [2:0]  count;
  logic        wide_mode;
  logic [2:0]  mode_in;
  logic [19:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [2:0]  mode_out;
  logic        done, err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ring_rotate_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .carry_in(carry_in), .count(count), .wide_mode(wide_mode),
    .mode_in(mode_in), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .mode_out(mode_out),
    .done(done), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bit-serial model: n single-position moves around the carry ring.
  task automatic model(input logic [19:0] op, input logic cin, input int n,
                       input logic wide, output logic [19:0] res,
                       output logic cout);
    logic [19:0] v;
    logic c;
    logic leave;
    v = wide ? op : {4'h0, op[15:0]};
    c = cin;
    for (int i = 0; i < n; i++) begin
      leave = v[0];
      v = v >> 1;
      if (wide) v[19] = c; else v[15] = c;
      c = leave;
    end
    res = v;
    cout = c;
  endtask

  task automatic issue(input logic [19:0] op, input logic cin, input logic [2:0] cnt,
                       input logic wide, input logic [2:0] md);
    @(negedge clk);
    operand = op; carry_in = cin; count = cnt; wide_mode = wide; mode_in = md;
    start = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic run_valid(input logic [19:0] op, input logic cin, input int n,
                           input logic wide, input logic [2:0] md);
    logic [19:0] er;
    logic ec;
    model(op, cin, n, wide, er, ec);
    issue(op, cin, 3'(n), wide, md);
    chk("R10 done after start", {31'd0, done}, 32'd1);
    chk(wide ? "R1 R2 wide result" : "R1 R3 narrow result", {12'd0, result}, {12'd0, er});
    chk("R4 carry", {31'd0, flag_c}, {31'd0, ec});
    chk("R5 negative", {31'd0, flag_n}, {31'd0, wide ? er[19] : er[15]});
    chk("R6 zero", {31'd0, flag_z}, {31'd0, (er == 20'd0)});
    chk("R7 overflow", {31'd0, flag_v}, 32'd0);
    chk("R8 mode bits", {29'd0, mode_out}, {29'd0, md});
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; operand = 20'hFFFFF; carry_in = 1'b1;
    count = 3'd2; wide_mode = 1'b1; mode_in = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset result", {12'd0, result}, 32'd0);
    chk("R11 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    chk("R11 reset mode/done/err", {27'd0, mode_out, done, err}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_worked;
    // Wide, carry 1, three places: bit 17 gets the carry.
    run_valid(20'h12340, 1'b1, 3, 1'b1, 3'b101);
    chk("R2 worked wide value", {12'd0, result}, 32'h22468);
    chk("R4 worked wide carry = bit2", {31'd0, flag_c}, 32'd0);
    // Narrow, two places: old LSB to bit 15, carry to bit 14, upper nibble dropped.
    run_valid(20'hF0001, 1'b1, 2, 1'b0, 3'b010);
    chk("R3 worked narrow value", {12'd0, result}, 32'h0C000);
    chk("R5 worked narrow negative", {31'd0, flag_n}, 32'd1);
  endtask

  task automatic t_sweep;
    logic [19:0] pats [0:2];
    pats[0] = 20'h00000; pats[1] = 20'hFFFFF; pats[2] = 20'hA5C3E;
    for (int n = 1; n <= 4; n++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 2; c++) begin
          for (int p = 0; p < 3; p++)
            run_valid(pats[p], c[0], n, w[0], 3'(n + p));
          for (int b = 0; b < 20; b++)
            run_valid(20'd1 << b, c[0], n, w[0], 3'(b));
        end
  endtask

  task automatic t_invalid;
    logic [19:0] keep_r;
    logic [3:0]  keep_f;
    logic [2:0]  keep_m;
    logic [2:0]  bad [0:3];
    bad[0] = 3'd0; bad[1] = 3'd5; bad[2] = 3'd6; bad[3] = 3'd7;
    for (int i = 0; i < 4; i++) begin
      run_valid(20'h3C00F, 1'b1, 1, 1'b1, 3'b011);
      keep_r = result; keep_f = {flag_n, flag_z, flag_c, flag_v}; keep_m = mode_out;
      issue(20'h00000, 1'b0, bad[i], 1'b0, 3'b100);
      chk("R9 err pulse", {31'd0, err}, 32'd1);
      chk("R9 no done", {31'd0, done}, 32'd0);
      chk("R9 result held", {12'd0, result}, {12'd0, keep_r});
      chk("R9 flags held", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, keep_f});
      chk("R9 mode held", {29'd0, mode_out}, {29'd0, keep_m});
      @(negedge clk);
      start = 1'b0;
      @(posedge clk);
      #1;
      chk("R9 err one cycle", {31'd0, err}, 32'd0);
    end
  endtask

  task automatic t_idle;
    logic [19:0] keep_r;
    run_valid(20'h8F0F1, 1'b0, 4, 1'b1, 3'b110);
    keep_r = result;
    @(negedge clk);
    operand = 20'h12345; carry_in = 1'b1; count = 3'd1; mode_in = 3'b001;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 idle result held", {12'd0, result}, {12'd0, keep_r});
    chk("R10 idle mode held", {29'd0, mode_out}, 32'd6);
    chk("R10 idle no pulses", {30'd0, done, err}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_worked();
    t_sweep();
    t_invalid();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule